// File: doc/BRIEF.md
# Paged External I/O Strobe Generator

This block sits between a simple processor-side request port and an external 8-bit I/O bus that covers a 64 KB address space. Each access names a 16-bit address; the top three bits pick one of eight 8 KB pages and the remaining thirteen bits are presented to the external bus. For every access the block produces shared active-low read, write and buffer-enable strobes, and it can also pulse one dedicated pin per page.

Each of the eight page pins can serve as a plain output driven from a data register or as the strobe for its own page. As a strobe, a pin follows its own control byte. That byte selects the pulse shape (chip select, write pulse, read pulse, or read-or-write), a wait-state count that stretches the strobe phase, a write-enable gate, and the active level. Software loads a function register, a direction register, an output data register and the eight control bytes through a small configuration write port.

An access opens with one address-setup cycle. A strobe phase of one cycle plus the page's wait states follows. `busy` stays high over the whole access, and read data is taken from the bus on its final cycle.

Top module: `pagedIoStrobe`

## Requirements
- R1: After reset the function, direction and output data registers and all control bytes are zero, so `pinOe` and `pinOut` are 0. `busy` and `rdValid` are 0, and `ioRdN`, `ioWrN` and `bufEnN` are high.
- R2: On an accepted request the page is `reqAddr[15:13]`. `extAddr` takes `reqAddr[12:0]` one cycle after acceptance and holds that value until the next accepted request.
- R3: `reqStart` is accepted only while `busy` is low. `busy` then rises on the next cycle and stays high for 2+W cycles, where W is the page's wait count: one setup cycle followed by W+1 strobe cycles. `reqStart` while `busy` is high is ignored.
- R4: `bufEnN` is low in every strobe cycle. `ioRdN` is low in the strobe cycles of reads. `ioWrN` is low in the strobe cycles of writes only when the page's write-enable bit is set. `ioRdN` and `ioWrN` are never low together.
- R5: On a read, `rdData` takes `extDataIn` at the clock edge that ends the last strobe cycle. `rdValid` is high for exactly the one cycle that follows that edge.
- R6: During every busy cycle of a write, `extDataOe` is high and `extDataOut` carries the write data. `extDataOe` is low at all other times.
- R7: A pin whose function bit is 0 drives its output data register bit, unaffected by any access.
- R8: A pin whose function bit is 1 is active only during an access to its own page. The mode field selects when it is active: 0 chip select, over all busy cycles; 1 write pulse, in strobe cycles of writes and gated by write-enable; 2 read pulse, in strobe cycles of reads; 3 either pulse, with the write part gated.
- R9: The polarity bit of a control byte selects the active level of a strobe pin: 0 gives active-low (idle high), 1 gives active-high (idle low).
- R10: `pinOe` always equals the direction register.
- R11: Configuration map for `cfgAddr`: 0 is the function register, 1 the direction register, 2 the output data register, and 3 to 7 are ignored. 8+n is the control byte of page n, with bits [1:0] the mode, [4:2] the wait count, [5] write-enable and [6] polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqStart | input | 1 | Start an access |
| reqWrite | input | 1 | 1 write, 0 read |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| rdData | output | 8 | Captured read data |
| rdValid | output | 1 | One-cycle read data valid |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register select |
| cfgWdata | input | 8 | Configuration write data |
| extAddr | output | 13 | Offset within page on the external bus |
| extDataOut | output | 8 | External write data |
| extDataOe | output | 1 | External data drive enable |
| extDataIn | input | 8 | External read data |
| ioRdN | output | 1 | Shared read strobe, active low |
| ioWrN | output | 1 | Shared write strobe, active low |
| bufEnN | output | 1 | Buffer enable, active low |
| pinOut | output | 8 | Page pin output values |
| pinOe | output | 8 | Page pin output enables |

## Verification
The bench uses the default parameters: eight pages, a 16-bit address, 8-bit data and a 3-bit wait field. With these values both the lowest page and the highest page are reachable, and so is the largest stretch of seven wait states. All four pin modes, both polarities and the gated write path are mixed across different pages, and two pages stay in plain output mode. A behavioural model tracks each access by cycle index, and every output is compared on every clock against that model.

// File: rtl/ioPagerPkg.sv
package ioPagerPkg;
  typedef struct packed {
    logic load;    // request accepted this cycle
    logic setup;   // address setup cycle
    logic strobe;  // strobe phase cycle
    logic last;    // final strobe cycle
  } pagerCtrlT;

  typedef enum logic [1:0] {
    MODE_CS = 2'd0,
    MODE_WR = 2'd1,
    MODE_RD = 2'd2,
    MODE_RW = 2'd3
  } pinModeT;
endpackage

// File: rtl/ioPagerCtrl.sv
module ioPagerCtrl
  import ioPagerPkg::*;
#(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [WAIT_W-1:0] selWait,
  output logic              busy,
  output pagerCtrlT         ctrl
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE} stateT;
  stateT             state;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE:   if (reqStart) state <= S_SETUP;
        S_SETUP: begin
          state   <= S_STROBE;
          waitCnt <= selWait;
        end
        S_STROBE: begin
          if (waitCnt == '0) state <= S_IDLE;
          else waitCnt <= waitCnt - 1'b1;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load   = (state == S_IDLE) && reqStart;
    ctrl.setup  = (state == S_SETUP);
    ctrl.strobe = (state == S_STROBE);
    ctrl.last   = (state == S_STROBE) && (waitCnt == '0);
    busy        = (state != S_IDLE);
  end

  // R3
  start_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqStart));
  // R3
  setup_then_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setup |=> ctrl.strobe);
endmodule

// File: rtl/ioPagerDatapath.sv
module ioPagerDatapath
  import ioPagerPkg::*;
#(
  parameter int PAGES  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3,
  localparam int PAGE_BITS = $clog2(PAGES),
  localparam int OFFS_W    = ADDR_W - PAGE_BITS,
  localparam int CTRL_W    = WAIT_W + 4,
  localparam int CFG_AW    = PAGE_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pagerCtrlT         ctrl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [DATA_W-1:0] extDataIn,
  output logic [WAIT_W-1:0] selWait,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [OFFS_W-1:0] extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              bufEnN,
  output logic [PAGES-1:0]  pinOut,
  output logic [PAGES-1:0]  pinOe
);
  localparam int WE_BIT  = WAIT_W + 2;
  localparam int POL_BIT = WAIT_W + 3;

  logic [PAGES-1:0]     fnReg, dirReg, outReg;
  logic [CTRL_W-1:0]    ctlReg [PAGES];
  logic [PAGE_BITS-1:0] pageQ;
  logic                 isWrQ;
  logic                 active, selWe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnReg  <= '0;
      dirReg <= '0;
      outReg <= '0;
      for (int i = 0; i < PAGES; i++) ctlReg[i] <= '0;
    end else if (cfgWe) begin
      if (cfgAddr[CFG_AW-1]) ctlReg[cfgAddr[PAGE_BITS-1:0]] <= cfgWdata[CTRL_W-1:0];
      else begin
        case (cfgAddr[PAGE_BITS-1:0])
          PAGE_BITS'(0): fnReg  <= cfgWdata[PAGES-1:0];
          PAGE_BITS'(1): dirReg <= cfgWdata[PAGES-1:0];
          PAGE_BITS'(2): outReg <= cfgWdata[PAGES-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ      <= '0;
      extAddr    <= '0;
      extDataOut <= '0;
      isWrQ      <= 1'b0;
      rdData     <= '0;
      rdValid    <= 1'b0;
    end else begin
      if (ctrl.load) begin
        pageQ      <= reqAddr[ADDR_W-1:OFFS_W];
        extAddr    <= reqAddr[OFFS_W-1:0];
        extDataOut <= reqWdata;
        isWrQ      <= reqWrite;
      end
      rdValid <= ctrl.last && !isWrQ;
      if (ctrl.last && !isWrQ) rdData <= extDataIn;
    end
  end

  always_comb begin
    active    = ctrl.setup || ctrl.strobe;
    selWait   = ctlReg[pageQ][WAIT_W+1:2];
    selWe     = ctlReg[pageQ][WE_BIT];
    ioRdN     = !(ctrl.strobe && !isWrQ);
    ioWrN     = !(ctrl.strobe && isWrQ && selWe);
    bufEnN    = !ctrl.strobe;
    extDataOe = active && isWrQ;
    pinOe     = dirReg;
  end

  for (genvar g = 0; g < PAGES; g++) begin : gPin
    pinModeT modeG;
    logic    pulseG, hitG;
    assign modeG = pinModeT'(ctlReg[g][1:0]);
    always_comb begin
      unique case (modeG)
        MODE_CS: pulseG = active;
        MODE_WR: pulseG = ctrl.strobe && isWrQ && ctlReg[g][WE_BIT];
        MODE_RD: pulseG = ctrl.strobe && !isWrQ;
        MODE_RW: pulseG = ctrl.strobe && (isWrQ ? ctlReg[g][WE_BIT] : 1'b1);
        default: pulseG = 1'b0;
      endcase
      hitG = pulseG && (pageQ == PAGE_BITS'(g));
    end
    assign pinOut[g] = fnReg[g] ? (ctlReg[g][POL_BIT] ? hitG : !hitG) : outReg[g];
  end

  // R4
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!ioRdN && !ioWrN));
  // R4
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ioWrN |-> selWe);
  // R3
  setup_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(bufEnN) |-> $past(ctrl.setup));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active)) |-> $stable(extAddr));
endmodule

// File: rtl/pagedIoStrobe.sv
module pagedIoStrobe
  import ioPagerPkg::*;
#(
  parameter int PAGES  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 3,
  localparam int PAGE_BITS = $clog2(PAGES),
  localparam int OFFS_W    = ADDR_W - PAGE_BITS,
  localparam int CFG_AW    = PAGE_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output logic [OFFS_W-1:0] extAddr,
  output logic [DATA_W-1:0] extDataOut,
  output logic              extDataOe,
  input  logic [DATA_W-1:0] extDataIn,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              bufEnN,
  output logic [PAGES-1:0]  pinOut,
  output logic [PAGES-1:0]  pinOe
);
  pagerCtrlT         ctrl;
  logic [WAIT_W-1:0] selWait;

  ioPagerCtrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .selWait(selWait),
    .busy(busy), .ctrl(ctrl)
  );

  ioPagerDatapath #(.PAGES(PAGES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .extDataIn(extDataIn), .selWait(selWait),
    .rdData(rdData), .rdValid(rdValid),
    .extAddr(extAddr), .extDataOut(extDataOut), .extDataOe(extDataOe),
    .ioRdN(ioRdN), .ioWrN(ioWrN), .bufEnN(bufEnN),
    .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: tb/pagedIoStrobe_bench.sv
module pagedIoStrobe_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStart = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        busy, rdValid, extDataOe, ioRdN, ioWrN, bufEnN;
  logic [7:0]  rdData, extDataOut, pinOut, pinOe;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic [12:0] extAddr;
  logic [7:0]  extDataIn = '0;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  pagedIoStrobe u_pagedIoStrobe (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .rdData(rdData),
    .rdValid(rdValid), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .extAddr(extAddr), .extDataOut(extDataOut), .extDataOe(extDataOe),
    .extDataIn(extDataIn), .ioRdN(ioRdN), .ioWrN(ioWrN), .bufEnN(bufEnN),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // Behavioural model state
  bit       mActive, mWrite, mRdValid;
  int       mCycle, mW, mPage;
  int       mOff, mData, mRd;
  bit [7:0] fn, dir, od;
  bit [7:0] ctl [8];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mWrite = 0; mRdValid = 0; mCycle = 0; mW = 0; mPage = 0;
      mOff = 0; mData = 0; mRd = 0; fn = 0; dir = 0; od = 0;
      for (int i = 0; i < 8; i++) ctl[i] = 0;
    end else begin
      bit wasActive;
      wasActive = mActive;
      mRdValid = 0;
      if (mActive) begin
        if (mCycle == mW + 1) begin
          if (!mWrite) begin mRd = int'(extDataIn); mRdValid = 1; end
          mActive = 0;
        end else mCycle++;
      end
      if (!wasActive && reqStart) begin
        mActive = 1; mCycle = 0;
        mPage = int'(reqAddr) / 8192; mOff = int'(reqAddr) % 8192;
        mWrite = reqWrite; mData = int'(reqWdata);
        mW = (int'(ctl[mPage]) / 4) % 8;
      end
      if (cfgWe) begin
        if (cfgAddr >= 8) ctl[cfgAddr - 8] = cfgWdata & 8'h7F;
        else if (cfgAddr == 0) fn = cfgWdata;
        else if (cfgAddr == 1) dir = cfgWdata;
        else if (cfgAddr == 2) od = cfgWdata;
      end
    end
  end

  function automatic bit [7:0] expPins();
    bit [7:0] r;
    bit strobe;
    strobe = mActive && mCycle >= 1;
    for (int i = 0; i < 8; i++) begin
      if (fn[i]) begin
        bit act, we;
        we = ctl[i][5];
        act = 0;
        if (mActive && mPage == i) begin
          case (ctl[i][1:0])
            2'd0: act = 1;
            2'd1: act = strobe && mWrite && we;
            2'd2: act = strobe && !mWrite;
            default: act = strobe && (mWrite ? we : 1'b1);
          endcase
        end
        r[i] = ctl[i][6] ? act : !act;
      end else r[i] = od[i];
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      bit strobe;
      strobe = mActive && mCycle >= 1;
      check("R3 busy", int'(busy), int'(mActive));
      check("R4 ioRdN", int'(ioRdN), int'(!(strobe && !mWrite)));
      check("R4 ioWrN", int'(ioWrN), int'(!(strobe && mWrite && ctl[mPage][5])));
      check("R4 bufEnN", int'(bufEnN), int'(!strobe));
      check("R2 extAddr", int'(extAddr), mOff);
      check("R6 extDataOe", int'(extDataOe), int'(mActive && mWrite));
      if (mActive && mWrite) check("R6 extDataOut", int'(extDataOut), mData);
      check("R8 pinOut", int'(pinOut), int'(expPins()));
      check("R10 pinOe", int'(pinOe), int'(dir));
      check("R5 rdValid", int'(rdValid), int'(mRdValid));
      if (mRdValid) check("R5 rdData", int'(rdData), mRd);
    end
  end

  task automatic cfgWrite(input int a, input int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(a); cfgWdata = 8'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic txn(input bit wr, input int page, input int off, input int wd,
                     input int rin, input bit spam);
    @(negedge clk);
    reqStart = 1'b1; reqWrite = wr; reqAddr = 16'(page * 8192 + off);
    reqWdata = 8'(wd); extDataIn = 8'(rin);
    @(negedge clk);
    if (spam) begin
      // R3: second start while busy must be ignored
      reqAddr = 16'h1FFF; reqWrite = !wr;
    end else reqStart = 1'b0;
    @(negedge clk);
    reqStart = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pinOe", int'(pinOe), 0);
    check("R1 pinOut", int'(pinOut), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 strobes", int'({ioRdN, ioWrN, bufEnN}), 7);
    check("R1 rdValid", int'(rdValid), 0);

    // R11 map: 2 out data, 1 direction, 0 function, 8+n control
    cfgWrite(2, 'hA5);
    cfgWrite(1, 'hFF);
    cfgWrite(0, 'hF6);
    cfgWrite(3, 'hFF);          // R11 ignored offset
    cfgWrite(8 + 1, 'h28);      // CS, wait 2, we
    cfgWrite(8 + 2, 'h21);      // write pulse, wait 0, we
    cfgWrite(8 + 4, 'h5E);      // read pulse, wait 7, active high
    cfgWrite(8 + 5, 'h07);      // either, wait 1, write gated off
    cfgWrite(8 + 6, 'h6F);      // either, wait 3, we, active high
    cfgWrite(8 + 7, 'h05);      // write pulse, wait 1, write gated off
    @(negedge clk);
    check("R7 gpio pin0", int'(pinOut[0]), 1);
    check("R7 gpio pin3", int'(pinOut[3]), 0);
    check("R9 idle active-high pin6", int'(pinOut[6]), 0);
    check("R9 idle active-low pin1", int'(pinOut[1]), 1);
    check("R10 pinOe", int'(pinOe), 'hFF);

    txn(1, 1, 'h0123, 'h3C, 'h00, 0);
    txn(0, 1, 'h1ABC, 'h00, 'h5A, 0);
    txn(1, 2, 'h0001, 'h77, 'h00, 1);
    txn(0, 2, 'h0002, 'h00, 'hC3, 0);
    txn(0, 4, 'h1FFF, 'h00, 'h99, 0);
    txn(1, 4, 'h0000, 'h11, 'h00, 0);
    txn(1, 5, 'h0AAA, 'hEE, 'h00, 0);
    txn(0, 5, 'h0555, 'h00, 'h12, 1);
    txn(1, 6, 'h0040, 'h81, 'h00, 0);
    txn(0, 6, 'h0080, 'h00, 'h7E, 0);
    txn(1, 7, 'h1000, 'h42, 'h00, 0);
    txn(0, 0, 'h0010, 'h00, 'h24, 0);
    txn(1, 3, 'h0020, 'h5B, 'h00, 0);

    // R7: all pins back to plain outputs
    cfgWrite(0, 'h00);
    cfgWrite(2, 'h3C);
    txn(0, 6, 'h0003, 'h00, 'hA1, 0);
    check("R7 gpio after txn", int'(pinOut), 'h3C);
    cfgWrite(1, 'h0F);
    @(negedge clk);
    check("R10 pinOe partial", int'(pinOe), 'h0F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule